// File: doc/BRIEF.md
# PSK Carrier Phase Error Detector

This block turns a phase angle from a rectangular-to-polar stage into a signed carrier phase error. It strips the data modulation from a BPSK, QPSK or 8-PSK signal, or passes an unmodulated carrier's angle through unchanged. The method has two steps. A programmable phase offset is added first. The rotated angle is then multiplied by a power of two, with the result wrapping modulo one full turn. After this, every ideal constellation point lands on zero degrees, and any residual rotation shows up as a small signed error.

The phase word uses the whole code space for one turn. A mode select sets the left-shift amount, and a separate offset input sets the rotation. When the upstream path delivers integrate-and-dump results, a gating option lets only samples flagged as end of symbol produce an error term. The error is registered and comes with its own valid strobe, ready for a carrier loop filter.

Top module: `ped_top`

## Requirements
- R1: While reset is high and in the cycle after it, `err_valid` is 0 and `err_out` is 0x00.
- R2: The phase word spans one turn over its 256 codes, so 0x20 is 45 degrees and 0x10 is 22.5 degrees. The output is ((phase + offset) mod 256) shifted left by the mode's shift count, keeping only the low 8 bits, and is read as two's complement.
- R3: Mode encoding: 2'b00 is carrier with shift 0, 2'b01 is BPSK with shift 1, 2'b10 is QPSK with shift 2, and 2'b11 is 8-PSK with shift 3.
- R4: An accepted sample makes `err_valid` high on the clock edge that follows it, for exactly one cycle per accepted sample. Back-to-back samples give back-to-back outputs.
- R5: `err_out` keeps its last value in every cycle without an accepted sample.
- R6: `cfg_mode` and `cfg_offset` are used only in a cycle with `ph_valid` high. Changing them while `ph_valid` is low does not alter `err_out` or `err_valid`.
- R7: With `gate_eos` = 1, a sample whose `ph_eos` is 0 is ignored, so `err_valid` stays 0 and `err_out` is unchanged. With `gate_eos` = 0, every valid sample is accepted whatever `ph_eos` is.
- R8: Ideal points fold to 0x00. This covers BPSK points 0x00 and 0x80 with offset 0x00, QPSK points 0x20, 0x60, 0xA0 and 0xE0 with offset 0x20, and 8-PSK points 0x10 + 0x20*k with offset 0x10.
- R9: Bits shifted past the MSB are dropped. For example, QPSK phase 0x1F with offset 0x20 gives 0xFC (-4), and an offset addition that passes 0xFF wraps.
- R10: For shift n, the n least significant bits of `err_out` are zero after every accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_valid | input | 1 | Phase sample strobe |
| ph_angle | input | 8 | Phase angle, one turn over the 256 codes |
| ph_eos | input | 1 | Sample is the end of a symbol |
| gate_eos | input | 1 | Accept only end-of-symbol samples |
| cfg_mode | input | 2 | Modulation select, which sets the shift count |
| cfg_offset | input | 8 | Phase rotation added before the shift |
| err_valid | output | 1 | Phase error strobe |
| err_out | output | 8 | Signed phase error |

## Verification
A wrong shift count or a wrong offset sum shows up in `err_out` at the very next clock edge after the sample. It appears as nonzero low bits, or as a constellation point that does not fold to zero. A fault in the acceptance gate or in the output register shows in the same cycle. Either `err_valid` pulses when it should stay low, or `err_out` moves between samples. These faults never hide for more than one cycle past the stimulus, because the block keeps no state beyond its output register.

// File: rtl/ped_pkg.sv
package ped_pkg;

    localparam int PHASE_BITS = 8;
    localparam int MODE_COUNT = 4;

    typedef enum logic [1:0] {
        MODE_CARRIER = 2'b00,
        MODE_BPSK    = 2'b01,
        MODE_QPSK    = 2'b10,
        MODE_8PSK    = 2'b11
    } ped_mode_e;

    // Mask of the low bits that a given shift count forces to zero.
    function automatic logic [PHASE_BITS-1:0] zero_mask(input logic [1:0] shift);
        logic [PHASE_BITS-1:0] one;
        one = PHASE_BITS'(1);
        return (one << shift) - one;
    endfunction

endpackage

// File: rtl/ped_accept.sv
module ped_accept (
    input  logic valid_in,
    input  logic eos_in,
    input  logic gate_en,
    output logic take
);
    always_comb begin
        take = valid_in & (~gate_en | eos_in);
    end
endmodule

// File: rtl/ped_rotate.sv
module ped_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] angle,
    input  logic [W-1:0] offset,
    output logic [W-1:0] rotated
);
    // Sum wraps modulo one full turn.
    always_comb begin
        rotated = angle + offset;
    end
endmodule

// File: rtl/ped_fold.sv
module ped_fold #(
    parameter int W      = 8,
    parameter int NMODES = 4,
    localparam int SEL_W = (NMODES > 1) ? $clog2(NMODES) : 1
) (
    input  logic [W-1:0]     rotated,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     folded
);
    logic [W-1:0] cand [NMODES];

    for (genvar k = 0; k < NMODES; k++) begin : g_shift
        // Power-of-two phase multiply; carries past the MSB drop out.
        assign cand[k] = rotated << k;
    end

    always_comb begin
        if (int'(sel) < NMODES) folded = cand[sel];
        else                    folded = rotated;
    end
endmodule

// File: rtl/ped_top.sv
module ped_top #(
    parameter int W      = ped_pkg::PHASE_BITS,
    parameter int NMODES = ped_pkg::MODE_COUNT,
    localparam int SEL_W = (NMODES > 1) ? $clog2(NMODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_valid,
    input  logic [W-1:0]     ph_angle,
    input  logic             ph_eos,
    input  logic             gate_eos,
    input  logic [SEL_W-1:0] cfg_mode,
    input  logic [W-1:0]     cfg_offset,
    output logic             err_valid,
    output logic [W-1:0]     err_out
);
    logic         take;
    logic [W-1:0] rotated;
    logic [W-1:0] folded;

    ped_accept u_accept (
        .valid_in (ph_valid),
        .eos_in   (ph_eos),
        .gate_en  (gate_eos),
        .take     (take)
    );

    ped_rotate #(.W(W)) u_rotate (
        .angle   (ph_angle),
        .offset  (cfg_offset),
        .rotated (rotated)
    );

    ped_fold #(.W(W), .NMODES(NMODES)) u_fold (
        .rotated (rotated),
        .sel     (cfg_mode),
        .folded  (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_out   <= '0;
        end else begin
            err_valid <= take;
            if (take) err_out <= folded;
        end
    end
endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
    parameter int W     = 8,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ph_valid,
    input logic [W-1:0]     ph_angle,
    input logic             ph_eos,
    input logic             gate_eos,
    input logic [SEL_W-1:0] cfg_mode,
    input logic [W-1:0]     cfg_offset,
    input logic             err_valid,
    input logic [W-1:0]     err_out
);
    logic         acc;
    logic [W-1:0] mask_q;

    assign acc = ph_valid && (!gate_eos || ph_eos);

    always_ff @(posedge clk) begin
        if (rst)      mask_q <= '0;
        else if (acc) mask_q <= (W'(1) << cfg_mode) - W'(1);
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!err_valid && err_out == '0));

    // R4
    a_r4_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        acc |=> err_valid);

    // R7
    a_r7_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && gate_eos && !ph_eos) |=> !err_valid);

    // R5
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(err_out));

    // R2, R3: carrier mode with zero offset is a pass-through
    a_r2_carrier_pass: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_mode == '0 && cfg_offset == '0) |=> (err_out == $past(ph_angle)));

    // R10
    a_r10_low_zero: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ((err_out & mask_q) == '0));
endmodule

bind ped_top ped_checker #(.W(W), .SEL_W(SEL_W)) u_ped_checker (
    .clk        (clk),
    .rst        (rst),
    .ph_valid   (ph_valid),
    .ph_angle   (ph_angle),
    .ph_eos     (ph_eos),
    .gate_eos   (gate_eos),
    .cfg_mode   (cfg_mode),
    .cfg_offset (cfg_offset),
    .err_valid  (err_valid),
    .err_out    (err_out)
);

// File: tb/tb_ped_top.sv
`timescale 1ns/1ps
module tb_ped_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ph_valid;
    logic [7:0] ph_angle;
    logic       ph_eos;
    logic       gate_eos;
    logic [1:0] cfg_mode;
    logic [7:0] cfg_offset;
    logic       err_valid;
    logic [7:0] err_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ped_top dut (
        .clk(clk), .rst(rst), .ph_valid(ph_valid), .ph_angle(ph_angle),
        .ph_eos(ph_eos), .gate_eos(gate_eos), .cfg_mode(cfg_mode),
        .cfg_offset(cfg_offset), .err_valid(err_valid), .err_out(err_out)
    );

    function automatic logic [7:0] model(input logic [7:0] p, input logic [7:0] o,
                                         input logic [1:0] m);
        logic [7:0] r;
        r = p + o;
        return r << m;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one sample at a falling edge, then sample outputs at the next falling edge.
    task automatic one_sample(input logic [7:0] p, input logic [7:0] o, input logic [1:0] m,
                              input logic eos, input logic gate);
        @(negedge clk);
        ph_valid = 1'b1; ph_angle = p; cfg_offset = o; cfg_mode = m;
        ph_eos = eos; gate_eos = gate;
        @(negedge clk);
        ph_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; ph_valid = 1'b0; ph_angle = 8'h00; ph_eos = 1'b0;
        gate_eos = 1'b0; cfg_mode = 2'b00; cfg_offset = 8'h00;
        repeat (4) @(negedge clk);
        check("R1 valid", {7'd0, err_valid}, 8'h00);
        check("R1 err", err_out, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", {7'd0, err_valid}, 8'h00);
    endtask

    task automatic t_carrier();
        logic [7:0] pts [4] = '{8'h00, 8'h37, 8'h80, 8'hFF};
        foreach (pts[i]) begin
            one_sample(pts[i], 8'h00, 2'b00, 1'b0, 1'b0);
            check("R3 carrier pass", err_out, pts[i]);
        end
        one_sample(8'hF0, 8'h20, 2'b00, 1'b0, 1'b0);
        check("R2 offset wrap", err_out, 8'h10);
    endtask

    task automatic t_fold();
        one_sample(8'h00, 8'h00, 2'b01, 1'b0, 1'b0); check("R8 bpsk 0", err_out, 8'h00);
        one_sample(8'h80, 8'h00, 2'b01, 1'b0, 1'b0); check("R8 bpsk 180", err_out, 8'h00);
        for (int k = 0; k < 4; k++) begin
            one_sample(8'(8'h20 + 8'h40 * k), 8'h20, 2'b10, 1'b0, 1'b0);
            check("R8 qpsk point", err_out, 8'h00);
        end
        for (int k = 0; k < 8; k++) begin
            one_sample(8'(8'h10 + 8'h20 * k), 8'h10, 2'b11, 1'b0, 1'b0);
            check("R8 8psk point", err_out, 8'h00);
        end
    endtask

    task automatic t_wrap();
        one_sample(8'h1F, 8'h20, 2'b10, 1'b0, 1'b0); check("R9 qpsk neg", err_out, 8'hFC);
        one_sample(8'h41, 8'h00, 2'b01, 1'b0, 1'b0); check("R9 bpsk", err_out, 8'h82);
        one_sample(8'h13, 8'h10, 2'b11, 1'b0, 1'b0); check("R9 8psk", err_out, 8'h18);
        one_sample(8'hB7, 8'h10, 2'b11, 1'b0, 1'b0);
        check("R10 low bits zero", err_out & 8'h07, 8'h00);
        check("R2 8psk value", err_out, model(8'hB7, 8'h10, 2'b11));
    endtask

    task automatic t_latency();
        logic [7:0] ps [3] = '{8'h05, 8'h6A, 8'hC3};
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            ph_valid = 1'b1; ph_angle = ps[i]; cfg_offset = 8'h20; cfg_mode = 2'b10;
            ph_eos = 1'b0; gate_eos = 1'b0;
            @(negedge clk);
            check("R4 stream valid", {7'd0, err_valid}, 8'h01);
            check("R4 stream data", err_out, model(ps[i], 8'h20, 2'b10));
        end
        ph_valid = 1'b0;
        @(negedge clk);
        check("R4 single pulse", {7'd0, err_valid}, 8'h00);
        check("R5 held", err_out, model(8'hC3, 8'h20, 2'b10));
    endtask

    task automatic t_cfg_ignore();
        logic [7:0] held;
        one_sample(8'h2C, 8'h00, 2'b01, 1'b0, 1'b0);
        held = err_out;
        check("R6 base", held, 8'h58);
        for (int i = 0; i < 3; i++) begin
            cfg_mode = 2'(i + 2); cfg_offset = 8'(8'h33 * (i + 1)); ph_angle = 8'h99;
            @(negedge clk);
            check("R6 idle no valid", {7'd0, err_valid}, 8'h00);
            check("R6 idle err kept", err_out, held);
        end
        one_sample(8'h2C, 8'h10, 2'b00, 1'b0, 1'b0);
        check("R6 new cfg used", err_out, 8'h3C);
    endtask

    task automatic t_eos();
        logic [7:0] held;
        one_sample(8'h11, 8'h00, 2'b00, 1'b0, 1'b0);
        held = err_out;
        @(negedge clk);
        ph_valid = 1'b1; ph_angle = 8'h55; cfg_mode = 2'b01; cfg_offset = 8'h00;
        ph_eos = 1'b0; gate_eos = 1'b1;
        @(negedge clk);
        ph_valid = 1'b0;
        check("R7 gated no valid", {7'd0, err_valid}, 8'h00);
        check("R7 gated err kept", err_out, held);
        one_sample(8'h55, 8'h00, 2'b01, 1'b1, 1'b1);
        check("R7 eos valid", {7'd0, err_valid}, 8'h01);
        check("R7 eos data", err_out, 8'hAA);
        one_sample(8'h07, 8'h00, 2'b00, 1'b0, 1'b0);
        check("R7 ungated accepts", err_out, 8'h07);
    endtask

    initial begin
        t_reset();
        t_carrier();
        t_fold();
        t_wrap();
        t_latency();
        t_cfg_ignore();
        t_eos();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule